// File: doc/BRIEF.md
# Guarded Commit Predicate File

This block holds the one-bit guard predicates of a wide-issue datapath that has several slots per instruction word. Every issue slot presents a valid flag and the index of the predicate that guards it. The block answers, in the same cycle, whether the operation commits or is squashed into a no-op. A squashed operation writes no register and has no side effect.

Predicates are produced by compare slots. Each compare slot takes two integer operands, a condition code and two destination indices. On one clock edge it writes the compare outcome to its true destination and the inverted outcome to its false destination. A two-armed conditional can then be flattened into straight-line code: the then-arm is guarded by the true destination and the else-arm by the false destination. Predicate 0 is a constant 1, so it serves as the "always" guard.

Top module: `pgrf_top`

## Requirements
- R1: A valid slot whose guard index is 0 always commits, because predicate 0 reads as 1 at all times.
- R2: A compare destination index of 0 writes nothing, and predicate 0 stays 1.
- R3: For each slot, commit = valid AND predicate[guard] and squash = valid AND NOT predicate[guard]. A slot with valid low raises neither output.
- R4: A valid compare writes its outcome to the true destination and the inverted outcome to the false destination, both on the same clock edge.
- R5: Condition codes: 0 equal, 1 not equal, 2 signed less, 3 signed less-or-equal, 4 signed greater, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal.
- R6: A compare write is seen by guard reads from the cycle after issue. A guard read in the issue cycle sees the old value.
- R7: When two compare slots in one word write the same predicate, the higher-numbered compare slot decides the value.
- R8: When one compare names the same predicate as both true and false destination, the false-destination (inverted) value is stored.
- R9: After reset every predicate except predicate 0 reads as 0.
- R10: A compare slot with valid low changes no predicate, whatever its other fields hold.
- R11: A predicate that no valid compare addresses keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_valid | input | NUM_SLOTS | Operation present in each issue slot |
| slot_guard_idx | input | NUM_SLOTS*IDX_W | Guard predicate index per slot, slot 0 in the low bits |
| slot_commit | output | NUM_SLOTS | Slot operation may take effect |
| slot_squash | output | NUM_SLOTS | Slot operation is turned into a no-op |
| cmp_valid | input | NUM_CMP | Compare present in each compare slot |
| cmp_a | input | NUM_CMP*DATA_W | First compare operand per compare slot |
| cmp_b | input | NUM_CMP*DATA_W | Second compare operand per compare slot |
| cmp_cond | input | NUM_CMP*3 | Condition code per compare slot |
| cmp_dst_t | input | NUM_CMP*IDX_W | Destination receiving the outcome |
| cmp_dst_f | input | NUM_CMP*IDX_W | Destination receiving the inverted outcome |

## Verification
A corrupted predicate bit shows up at the ports on the first later cycle in which any valid slot reads that index: commit and squash come out swapped for that slot. Stored state reaches the outputs through combinational read ports only, so a bad value from a compare becomes visible exactly one cycle after the compare issues. Bad write priority or a bad complement stays hidden until the losing or inverted destination is read. For that reason the bench reads every written destination in the following word.

// File: rtl/pgrf_pkg.sv
package pgrf_pkg;

  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    CC_EQ  = 3'd0,
    CC_NE  = 3'd1,
    CC_SLT = 3'd2,
    CC_SLE = 3'd3,
    CC_SGT = 3'd4,
    CC_SGE = 3'd5,
    CC_ULT = 3'd6,
    CC_UGE = 3'd7
  } cmp_cond_e;

endpackage

// File: rtl/pgrf_cmp.sv
module pgrf_cmp
  import pgrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [COND_W-1:0] cond,
  output logic              res
);

  logic eq;
  logic s_lt;
  logic u_lt;

  always_comb begin
    eq   = (opa == opb);
    s_lt = ($signed(opa) < $signed(opb));
    u_lt = (opa < opb);
  end

  always_comb begin
    unique case (cmp_cond_e'(cond))
      CC_EQ:   res = eq;
      CC_NE:   res = !eq;
      CC_SLT:  res = s_lt;
      CC_SLE:  res = s_lt || eq;
      CC_SGT:  res = !(s_lt || eq);
      CC_SGE:  res = !s_lt;
      CC_ULT:  res = u_lt;
      CC_UGE:  res = !u_lt;
      default: res = 1'b0;
    endcase
  end

endmodule

// File: rtl/pgrf_store.sv
module pgrf_store #(
  parameter int NUM_PRED = 32,
  parameter int NUM_CMP  = 2,
  parameter int IDX_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CMP-1:0]       wr_en,
  input  logic [NUM_CMP*IDX_W-1:0] wr_t_idx,
  input  logic [NUM_CMP*IDX_W-1:0] wr_f_idx,
  input  logic [NUM_CMP-1:0]       wr_val,
  output logic [NUM_PRED-1:0]      preds
);

  logic [NUM_PRED-1:1] pr_q;
  logic [NUM_PRED-1:1] pr_d;
  logic                pr_en;

  // next state: later compare slots overwrite earlier ones; within one
  // compare the inverted destination is applied last
  always_comb begin
    pr_d  = pr_q;
    pr_en = |wr_en;
    for (int c = 0; c < NUM_CMP; c++) begin
      if (wr_en[c]) begin
        if (wr_t_idx[c*IDX_W +: IDX_W] != '0)
          pr_d[wr_t_idx[c*IDX_W +: IDX_W]] = wr_val[c];
        if (wr_f_idx[c*IDX_W +: IDX_W] != '0)
          pr_d[wr_f_idx[c*IDX_W +: IDX_W]] = !wr_val[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= '0;
    end else if (pr_en) begin
      pr_q <= pr_d;
    end
  end

  assign preds = {pr_q, 1'b1};

endmodule

// File: rtl/pgrf_rdport.sv
module pgrf_rdport #(
  parameter int NUM_PRED = 32,
  parameter int IDX_W    = 5
) (
  input  logic                valid,
  input  logic [IDX_W-1:0]    idx,
  input  logic [NUM_PRED-1:0] preds,
  output logic                commit,
  output logic                squash
);

  logic guard;

  always_comb begin
    guard  = preds[idx];
    commit = valid && guard;
    squash = valid && !guard;
  end

endmodule

// File: rtl/pgrf_top.sv
module pgrf_top
  import pgrf_pkg::*;
#(
  parameter int NUM_PRED  = 32,
  parameter int NUM_SLOTS = 4,
  parameter int NUM_CMP   = 2,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        slot_valid,
  input  logic [NUM_SLOTS*IDX_W-1:0]  slot_guard_idx,
  output logic [NUM_SLOTS-1:0]        slot_commit,
  output logic [NUM_SLOTS-1:0]        slot_squash,
  input  logic [NUM_CMP-1:0]          cmp_valid,
  input  logic [NUM_CMP*DATA_W-1:0]   cmp_a,
  input  logic [NUM_CMP*DATA_W-1:0]   cmp_b,
  input  logic [NUM_CMP*COND_W-1:0]   cmp_cond,
  input  logic [NUM_CMP*IDX_W-1:0]    cmp_dst_t,
  input  logic [NUM_CMP*IDX_W-1:0]    cmp_dst_f
);

  logic [1:0]          rst_sync_q;
  logic                rst_n_int;
  logic [NUM_CMP-1:0]  cmp_res;
  logic [NUM_PRED-1:0] preds;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    pgrf_cmp #(.DATA_W(DATA_W)) u_cmp (
      .opa  (cmp_a[c*DATA_W +: DATA_W]),
      .opb  (cmp_b[c*DATA_W +: DATA_W]),
      .cond (cmp_cond[c*COND_W +: COND_W]),
      .res  (cmp_res[c])
    );
  end

  pgrf_store #(
    .NUM_PRED (NUM_PRED),
    .NUM_CMP  (NUM_CMP),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (cmp_valid),
    .wr_t_idx (cmp_dst_t),
    .wr_f_idx (cmp_dst_f),
    .wr_val   (cmp_res),
    .preds    (preds)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_rd
    pgrf_rdport #(
      .NUM_PRED (NUM_PRED),
      .IDX_W    (IDX_W)
    ) u_rd (
      .valid  (slot_valid[s]),
      .idx    (slot_guard_idx[s*IDX_W +: IDX_W]),
      .preds  (preds),
      .commit (slot_commit[s]),
      .squash (slot_squash[s])
    );
  end

endmodule

// File: rtl/pgrf_chk.sv
module pgrf_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_CMP   = 2,
  parameter int IDX_W     = 5
) (
  input logic                       clk,
  input logic                       rst_n_int,
  input logic [NUM_SLOTS-1:0]       slot_valid,
  input logic [NUM_SLOTS*IDX_W-1:0] slot_guard_idx,
  input logic [NUM_SLOTS-1:0]       slot_commit,
  input logic [NUM_SLOTS-1:0]       slot_squash,
  input logic [NUM_CMP-1:0]         cmp_valid,
  input logic [NUM_CMP*IDX_W-1:0]   cmp_dst_t,
  input logic [NUM_CMP*IDX_W-1:0]   cmp_dst_f,
  input logic [NUM_CMP-1:0]         cmp_res
);

  localparam int LAST = NUM_CMP - 1;

  logic [IDX_W-1:0] g0;
  logic [IDX_W-1:0] lt;
  logic [IDX_W-1:0] lf;

  assign g0 = slot_guard_idx[IDX_W-1:0];
  assign lt = cmp_dst_t[LAST*IDX_W +: IDX_W];
  assign lf = cmp_dst_f[LAST*IDX_W +: IDX_W];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // R1
    p0_commit_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
      (slot_valid[s] && slot_guard_idx[s*IDX_W +: IDX_W] == '0) |-> slot_commit[s]);
  end

  // R3
  commit_squash_split_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((slot_commit | slot_squash) == slot_valid) && ((slot_commit & slot_squash) == '0));

  // R4
  true_dst_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmp_valid[LAST] && lt != '0 && lt != lf) |=>
      (!slot_valid[0] || g0 != $past(lt) || slot_commit[0] == $past(cmp_res[LAST])));

  // R4
  false_dst_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmp_valid[LAST] && lf != '0) |=>
      (!slot_valid[0] || g0 != $past(lf) || slot_commit[0] == !$past(cmp_res[LAST])));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmp_valid == '0 && slot_valid[0]) |=>
      (!slot_valid[0] || g0 != $past(g0) || slot_commit[0] == $past(slot_commit[0])));

endmodule

bind pgrf_top pgrf_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .NUM_CMP   (NUM_CMP),
  .IDX_W     (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n_int      (rst_n_int),
  .slot_valid     (slot_valid),
  .slot_guard_idx (slot_guard_idx),
  .slot_commit    (slot_commit),
  .slot_squash    (slot_squash),
  .cmp_valid      (cmp_valid),
  .cmp_dst_t      (cmp_dst_t),
  .cmp_dst_f      (cmp_dst_f),
  .cmp_res        (cmp_res)
);

// File: tb/sim_pgrf_top.sv
module sim_pgrf_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int NS = 4;
  localparam int NC = 2;
  localparam int DW = 32;
  localparam int IW = 5;

  logic            clk;
  logic            rst_n;
  logic [NS-1:0]   slot_valid;
  logic [NS*IW-1:0] slot_guard_idx;
  logic [NS-1:0]   slot_commit;
  logic [NS-1:0]   slot_squash;
  logic [NC-1:0]   cmp_valid;
  logic [NC*DW-1:0] cmp_a;
  logic [NC*DW-1:0] cmp_b;
  logic [NC*3-1:0] cmp_cond;
  logic [NC*IW-1:0] cmp_dst_t;
  logic [NC*IW-1:0] cmp_dst_f;

  pgrf_top u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_valid     (slot_valid),
    .slot_guard_idx (slot_guard_idx),
    .slot_commit    (slot_commit),
    .slot_squash    (slot_squash),
    .cmp_valid      (cmp_valid),
    .cmp_a          (cmp_a),
    .cmp_b          (cmp_b),
    .cmp_cond       (cmp_cond),
    .cmp_dst_t      (cmp_dst_t),
    .cmp_dst_f      (cmp_dst_f)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests;
  int n_fail;
  bit done;

  // bench-side predicate model
  bit model [NP];

  // stimulus staging
  logic [NS-1:0] d_sv;
  int            d_gi [NS];
  logic [NC-1:0] d_cv;
  logic [DW-1:0] d_a [NC];
  logic [DW-1:0] d_b [NC];
  int            d_cc [NC];
  int            d_t [NC];
  int            d_f [NC];

  // scoreboard
  logic [2*NS-1:0] exp_q [$];
  string           tag_q [$];

  function automatic bit ref_cmp(logic [DW-1:0] a, logic [DW-1:0] b, int cc);
    case (cc)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) < $signed(b);
      3: return $signed(a) <= $signed(b);
      4: return $signed(a) > $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a < b;
      default: return a >= b;
    endcase
  endfunction

  task automatic clr();
    d_sv = '0;
    d_cv = '0;
    for (int i = 0; i < NS; i++) d_gi[i] = 0;
    for (int i = 0; i < NC; i++) begin
      d_a[i] = '0; d_b[i] = '0; d_cc[i] = 0; d_t[i] = 0; d_f[i] = 0;
    end
  endtask

  task automatic issue(string tag);
    logic [NS-1:0] ecm;
    logic [NS-1:0] esq;
    bit r;
    @(negedge clk);
    slot_valid = d_sv;
    cmp_valid  = d_cv;
    for (int i = 0; i < NS; i++) slot_guard_idx[i*IW +: IW] = IW'(d_gi[i]);
    for (int i = 0; i < NC; i++) begin
      cmp_a[i*DW +: DW]   = d_a[i];
      cmp_b[i*DW +: DW]   = d_b[i];
      cmp_cond[i*3 +: 3]  = 3'(d_cc[i]);
      cmp_dst_t[i*IW +: IW] = IW'(d_t[i]);
      cmp_dst_f[i*IW +: IW] = IW'(d_f[i]);
    end
    for (int i = 0; i < NS; i++) begin
      ecm[i] = d_sv[i] && model[d_gi[i]];
      esq[i] = d_sv[i] && !model[d_gi[i]];
    end
    exp_q.push_back({esq, ecm});
    tag_q.push_back(tag);
    for (int i = 0; i < NC; i++) begin
      if (d_cv[i]) begin
        r = ref_cmp(d_a[i], d_b[i], d_cc[i]);
        if (d_t[i] != 0) model[d_t[i]] = r;
        if (d_f[i] != 0) model[d_f[i]] = !r;
      end
    end
  endtask

  // read four predicates in one word, all slots valid
  task automatic read4(int p0i, int p1i, int p2i, int p3i, string tag);
    clr();
    d_sv = '1;
    d_gi[0] = p0i; d_gi[1] = p1i; d_gi[2] = p2i; d_gi[3] = p3i;
    issue(tag);
  endtask

  task automatic cmp1(int slot, logic [DW-1:0] a, logic [DW-1:0] b, int cc, int t, int f);
    d_cv[slot] = 1'b1;
    d_a[slot] = a; d_b[slot] = b; d_cc[slot] = cc; d_t[slot] = t; d_f[slot] = f;
  endtask

  // monitor: samples a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [2*NS-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({slot_squash, slot_commit} !== e) begin
          n_fail++;
          $display("FAIL %s: squash/commit actual %b/%b expected %b/%b",
                   t, slot_squash, slot_commit, e[2*NS-1:NS], e[NS-1:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    for (int i = 0; i < NP; i++) model[i] = 1'b0;
    model[0] = 1'b1;
    rst_n = 1'b0;
    slot_valid = '0; slot_guard_idx = '0; cmp_valid = '0;
    cmp_a = '0; cmp_b = '0; cmp_cond = '0; cmp_dst_t = '0; cmp_dst_f = '0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 and R1: reset state
    read4(0, 1, 17, 31, "R9 reset state");

    // R5 and R4: every condition code over several operand pairs
    for (int cc = 0; cc < 8; cc++) begin
      for (int pr = 0; pr < 3; pr++) begin
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        a = (pr == 0) ? 32'd5 : (pr == 1) ? 32'hFFFF_FFFD : 32'd7;
        b = (pr == 0) ? 32'd5 : 32'd5;
        if (pr == 2) b = 32'd2;
        clr();
        cmp1(1, a, b, cc, 1, 2);
        issue("R5 compare issue");
        read4(1, 2, 0, 1, "R5 R4 outcome and complement");
      end
    end

    // R6: same-cycle read sees old value, next cycle sees new
    clr();
    cmp1(0, 32'd1, 32'd1, 0, 3, 10);
    d_sv = '1; d_gi[0] = 3; d_gi[1] = 10; d_gi[2] = 3; d_gi[3] = 10;
    issue("R6 same-cycle old value");
    read4(3, 10, 3, 10, "R6 next-cycle new value");

    // R7: both compares target p4, higher slot wins
    clr();
    cmp1(0, 32'd1, 32'd1, 0, 4, 11);
    cmp1(1, 32'd1, 32'd1, 1, 4, 12);
    issue("R7 conflict issue");
    read4(4, 11, 12, 0, "R7 slot1 wins p4 low");
    clr();
    cmp1(0, 32'd1, 32'd1, 1, 4, 13);
    cmp1(1, 32'd1, 32'd1, 0, 4, 14);
    issue("R7 conflict issue 2");
    read4(4, 13, 14, 0, "R7 slot1 wins p4 high");
    clr();
    cmp1(0, 32'd9, 32'd3, 4, 6, 15);
    cmp1(1, 32'd9, 32'd3, 4, 16, 6);
    issue("R7 true vs false dst");
    read4(6, 15, 16, 0, "R7 slot1 false dst wins");

    // R8: same predicate as both destinations
    clr();
    cmp1(1, 32'd2, 32'd2, 0, 7, 7);
    issue("R8 self-pair issue");
    read4(7, 7, 0, 0, "R8 inverted value kept");

    // R2: writes aimed at p0 ignored
    clr();
    cmp1(0, 32'd1, 32'd2, 0, 0, 18);
    cmp1(1, 32'd1, 32'd1, 0, 19, 0);
    issue("R2 p0 write issue");
    read4(0, 18, 19, 0, "R2 p0 still one");

    // R10: invalid compare changes nothing
    clr();
    d_a[0] = 32'd1; d_b[0] = 32'd1; d_t[0] = 18; d_f[0] = 19;
    d_a[1] = 32'd1; d_b[1] = 32'd2; d_t[1] = 3;  d_f[1] = 4;
    issue("R10 invalid compare issue");
    read4(18, 19, 3, 4, "R10 predicates unchanged");

    // R3: if-conversion, then/else arms plus an empty slot
    clr();
    cmp1(0, 32'd20, 32'd8, 4, 8, 9);
    issue("R3 if-convert compare");
    clr();
    d_sv = 4'b1011; d_gi[0] = 8; d_gi[1] = 9; d_gi[2] = 8; d_gi[3] = 9;
    issue("R3 then/else arms");
    clr();
    cmp1(0, 32'd20, 32'd8, 3, 8, 9);
    issue("R3 if-convert reversed");
    clr();
    d_sv = 4'b0111; d_gi[0] = 8; d_gi[1] = 9; d_gi[2] = 0; d_gi[3] = 8;
    issue("R3 reversed arms");

    // R11: untouched predicates hold across idle and other writes
    clr();
    issue("R11 idle word");
    read4(3, 10, 15, 16, "R11 earlier values hold");

    clr();
    issue("drain");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule